// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost-Flags

This block carries 36-bit words from a producer clock domain to a consumer clock domain through a 64-entry buffer. The producer and consumer clocks may be unrelated or identical. Each side has an active-low select and an active-high enable. A rising edge of a side's clock moves one word only when both are asserted. The write side reports full and almost-full. The read side reports empty and almost-empty. All four flags are active-low, and each flag is registered in the clock domain of the side that uses it.

The almost-flags compare against one threshold, shared by both flags, held in each domain. While reset is held, each domain keeps loading the threshold from a two-bit select input. Each domain freezes its copy at the clock edge where that domain leaves reset, so later changes on the select pins have no effect. Pointers cross between the domains as Gray codes through two-stage synchronizers. The read word comes from an output register that loads only on an accepted read.

Top module: `dcfifo36`

## Requirements
- R1: A write is accepted only on a `wr_clk` rising edge with `wr_cs_n`=0 and `wr_en`=1, and a read is accepted only on an `rd_clk` rising edge with `rd_cs_n`=0 and `rd_en`=1. Any other combination changes neither the stored contents nor `rd_data`.
- R2: `empty_n` is 0 while `rst_n` is 0 and while the FIFO holds no words. After a word is written into an empty FIFO, `empty_n` is still 0 after the first `rd_clk` rising edge and becomes 1 after the second. A read attempted while `empty_n` is 0 is ignored and leaves `rd_data` unchanged.
- R3: `full_n` is 0 while `rst_n` is 0 and is 0 again when 64 words are stored. After `rst_n` rises, `full_n` stays 0 after the first `wr_clk` rising edge and becomes 1 after the second. A write attempted while `full_n` is 0 is ignored and its word is never read out.
- R4: `aempty_n` is 0 exactly when the number of stored words is at most the threshold. This is judged once the pointers have settled across domains.
- R5: `afull_n` is 0 exactly when the number of free entries (64 minus stored words) is at most the threshold. This is judged once the pointers have settled across domains. Both almost-flags are 0 during reset.
- R6: The threshold is 16 - 4*`ofs_sel`: code 00 gives 16, 01 gives 12, 10 gives 8 and 11 gives 4. It is taken from the value `ofs_sel` holds when reset ends. Changing `ofs_sel` after that has no effect until the next reset.
- R7: Words are read out in the order they were accepted. `rd_data` takes the next word on the rising edge that accepts the read and holds it until the next accepted read. `rd_data` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| ofs_sel | input | 2 | Threshold preset select, frozen at reset release |
| wr_cs_n | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| rd_cs_n | input | 1 | Read select, active low |
| rd_en | input | 1 | Read enable, active high |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
A write and a read can be presented on the same edge, and this matters most at the two limits. The bench fills all 64 entries and then drives a write and a read together. The read must return the oldest word and the write must be dropped. After the flags settle, `full_n` must be 1 with one free entry, and a full drain must never return the dropped word. On an empty FIFO the same pair is driven again. This time the read must leave `rd_data` unchanged, and the written word must be the one that the next read returns.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int SEL_W = 2;

    // Preset threshold for each select code: 16, 12, 8, 4
    function automatic int unsigned offset_of(logic [SEL_W-1:0] sel);
        return 16 - 4 * int'(sel);
    endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  ofs_sel,
    input  logic              cs_n,
    input  logic              en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic              full_n,
    output logic              afull_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wr_st_t;

    function automatic logic [PW-1:0] g2b(logic [PW-1:0] g);
        logic [PW-1:0] b;
        for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    wr_st_t        st_d, st_q;
    logic          rdy_q;
    logic [PW-1:0] thr_q;
    logic [PW-1:0] used, free;

    dcf_sync #(.W(1)) u_rdy (
        .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rdy_q)
    );

    always_comb begin
        used    = st_q.bin - g2b(rgray_sync);
        free    = PW'(DEPTH) - used;
        full_n  = rdy_q && (used != PW'(DEPTH));
        afull_n = rdy_q && (free > thr_q);
        we      = !cs_n && en && full_n;
        st_d      = st_q;
        st_d.bin  = st_q.bin + {{(PW-1){1'b0}}, we};
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Threshold follows the select pins until this domain leaves reset
    always_ff @(posedge clk) begin
        if (!rdy_q) thr_q <= PW'(offset_of(ofs_sel));
    end

    assign wgray = st_q.gray;
    assign waddr = st_q.bin[ADDR_W-1:0];

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rdy_q)
        used <= PW'(DEPTH));
    a_r3_write_blocked: assert property (@(posedge clk) disable iff (!rdy_q)
        (!full_n && !cs_n && en) |=> $stable(st_q.gray));
    a_r1_wr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !en) |=> $stable(st_q.gray));
    a_r5_full_in_afull: assert property (@(posedge clk) disable iff (!rdy_q)
        !full_n |-> !afull_n);
    a_r6_thr_frozen: assert property (@(posedge clk) disable iff (!rdy_q)
        rdy_q |=> $stable(thr_q));
    a_r7_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  ofs_sel,
    input  logic              cs_n,
    input  logic              en,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] data;
    } rd_st_t;

    function automatic logic [PW-1:0] g2b(logic [PW-1:0] g);
        logic [PW-1:0] b;
        for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    rd_st_t        st_d, st_q;
    logic          rdy_q;
    logic [PW-1:0] thr_q;
    logic [PW-1:0] used;
    logic          re;

    dcf_sync #(.W(1)) u_rdy (
        .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rdy_q)
    );

    always_comb begin
        used     = g2b(wgray_sync) - st_q.bin;
        empty_n  = rdy_q && (used != '0);
        aempty_n = rdy_q && (used > thr_q);
        re       = !cs_n && en && empty_n;
        st_d      = st_q;
        st_d.bin  = st_q.bin + {{(PW-1){1'b0}}, re};
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        st_d.data = re ? mem_rdata : st_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rdy_q) thr_q <= PW'(offset_of(ofs_sel));
    end

    assign rgray   = st_q.gray;
    assign raddr   = st_q.bin[ADDR_W-1:0];
    assign rd_data = st_q.data;

    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rdy_q)
        used <= PW'(DEPTH));
    a_r2_read_blocked: assert property (@(posedge clk) disable iff (!rdy_q)
        (!empty_n && !cs_n && en) |=> ($stable(st_q.gray) && $stable(rd_data)));
    a_r1_rd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !en) |=> ($stable(st_q.gray) && $stable(rd_data)));
    a_r4_empty_in_aempty: assert property (@(posedge clk) disable iff (!rdy_q)
        !empty_n |-> !aempty_n);
    a_r6_thr_frozen: assert property (@(posedge clk) disable iff (!rdy_q)
        rdy_q |=> $stable(thr_q));
    a_r7_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
endmodule

// File: rtl/dcfifo36.sv
module dcfifo36
    import dcf_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_cs_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_cs_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              we;
    logic [DATA_W-1:0] mem_rdata;

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .cs_n(wr_cs_n), .en(wr_en), .rgray_sync(rgray_ws),
        .wgray(wgray), .waddr(waddr), .we(we),
        .full_n(full_n), .afull_n(afull_n)
    );

    dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .cs_n(rd_cs_n), .en(rd_en), .wgray_sync(wgray_rs),
        .mem_rdata(mem_rdata), .rgray(rgray), .raddr(raddr),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rs)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_ws)
    );

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(mem_rdata)
    );
endmodule

// File: tb/dcfifo36_bench.sv
module dcfifo36_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {writes[6:0], reads[6:0], empty_n, aempty_n, full_n, afull_n}, threshold 16
    localparam logic [17:0] VECS [NVEC] = '{
        {7'd10, 7'd0,  4'b1011},
        {7'd7,  7'd0,  4'b1111},
        {7'd0,  7'd1,  4'b1011},
        {7'd32, 7'd0,  4'b1110},
        {7'd0,  7'd1,  4'b1111},
        {7'd17, 7'd0,  4'b1100},
        {7'd3,  7'd0,  4'b1100},
        {7'd0,  7'd64, 4'b0011},
        {7'd0,  7'd2,  4'b0011},
        {7'd1,  7'd0,  4'b1011}
    };

    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  ofs_sel = 2'b00;
    logic        wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [35:0] rd_data;

    int vec_cnt = 0, miss_cnt = 0;
    logic [35:0] mdl_q [64];
    int mdl_head = 0, mdl_tail = 0, mdl_cnt = 0, wseq = 0;
    logic [35:0] last_exp = '0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(CLK_PERIOD/2) rd_clk = ~rd_clk;

    dcfifo36 u_dcfifo36 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .ofs_sel(ofs_sel),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n),
        .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [35:0] next_word();
        return {4'(wseq * 3), 32'hC0DE_0000 + 32'(wseq)};
    endfunction

    task automatic settle();
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic mdl_push(input logic [35:0] w);
        mdl_q[mdl_tail] = w;
        mdl_tail = (mdl_tail + 1) % 64;
        mdl_cnt++;
    endtask

    task automatic mdl_pop();
        last_exp = mdl_q[mdl_head];
        mdl_head = (mdl_head + 1) % 64;
        mdl_cnt--;
    endtask

    task automatic do_reset(input logic [1:0] sel, input bit timing_chk);
        @(negedge wr_clk);
        rst_n = 1'b0;
        ofs_sel = sel;
        repeat (3) @(negedge wr_clk);
        if (timing_chk) begin
            chk("R2 empty_n in reset", {35'd0, empty_n}, 36'd0);
            chk("R3 full_n in reset", {35'd0, full_n}, 36'd0);
        end
        rst_n = 1'b1;
        @(negedge wr_clk);
        if (timing_chk) chk("R3 full_n one edge after reset", {35'd0, full_n}, 36'd0);
        @(negedge wr_clk);
        if (timing_chk) chk("R3 full_n two edges after reset", {35'd0, full_n}, 36'd1);
        ofs_sel = ~sel;
        mdl_head = 0; mdl_tail = 0; mdl_cnt = 0; last_exp = '0;
        settle();
    endtask

    task automatic wr_word();
        logic [35:0] w;
        w = next_word();
        wseq++;
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = w;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
        if (mdl_cnt < 64) mdl_push(w);
    endtask

    task automatic rd_word();
        @(negedge rd_clk);
        rd_cs_n = 1'b0; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_cs_n = 1'b1; rd_en = 1'b0;
        if (mdl_cnt > 0) begin
            mdl_pop();
            chk("R7 read order", rd_data, last_exp);
        end else begin
            chk("R2 read while empty holds data", rd_data, last_exp);
        end
    endtask

    task automatic both_word(input string tag);
        logic [35:0] w;
        bit acc_w, acc_r;
        w = next_word();
        wseq++;
        acc_w = (mdl_cnt < 64);
        acc_r = (mdl_cnt > 0);
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = w;
        rd_cs_n = 1'b0; rd_en = 1'b1;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
        rd_cs_n = 1'b1; rd_en = 1'b0;
        if (acc_r) mdl_pop();
        if (acc_w) mdl_push(w);
        chk(tag, rd_data, last_exp);
    endtask

    task automatic chk_flags(input logic [3:0] exp, input string ctx);
        chk({"R2 empty_n ", ctx},  {35'd0, empty_n},  {35'd0, exp[3]});
        chk({"R4 aempty_n ", ctx}, {35'd0, aempty_n}, {35'd0, exp[2]});
        chk({"R3 full_n ", ctx},   {35'd0, full_n},   {35'd0, exp[1]});
        chk({"R5 afull_n ", ctx},  {35'd0, afull_n},  {35'd0, exp[0]});
    endtask

    initial begin
        repeat (150000) @(posedge wr_clk);
        miss_cnt++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    initial begin
        // Reset state and release timing (R2, R3)
        do_reset(2'b00, 1'b1);

        // R1: unqualified writes are ignored
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b1; wr_data = next_word(); wseq++;
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_en = 1'b0; wr_data = next_word(); wseq++;
        @(negedge wr_clk);
        wr_cs_n = 1'b1;
        settle();
        chk("R1 unqualified write ignored", {35'd0, empty_n}, 36'd0);

        // R2: empty release on the second read edge after the write
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = next_word();
        mdl_push(next_word()); wseq++;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
        chk("R2 empty_n at write edge", {35'd0, empty_n}, 36'd0);
        @(negedge rd_clk);
        chk("R2 empty_n one read edge later", {35'd0, empty_n}, 36'd0);
        @(negedge rd_clk);
        chk("R2 empty_n two read edges later", {35'd0, empty_n}, 36'd1);

        // R1: unqualified reads are ignored
        @(negedge rd_clk);
        rd_cs_n = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_cs_n = 1'b0; rd_en = 1'b0;
        @(negedge rd_clk);
        rd_cs_n = 1'b1;
        settle();
        chk("R1 unqualified read keeps rd_data", rd_data, 36'd0);
        chk("R1 unqualified read keeps word", {35'd0, empty_n}, 36'd1);
        rd_word();

        // Table of write/read bursts, threshold 16
        do_reset(2'b00, 1'b0);
        for (int i = 0; i < NVEC; i++) begin
            for (int k = 0; k < int'(VECS[i][17:11]); k++) wr_word();
            for (int k = 0; k < int'(VECS[i][10:4]); k++) rd_word();
            settle();
            chk_flags(VECS[i][3:0], $sformatf("vector %0d", i));
        end

        // Write and read on the same edge at the full limit
        do_reset(2'b00, 1'b0);
        for (int k = 0; k < 64; k++) wr_word();
        settle();
        chk("R3 full_n at 64 words", {35'd0, full_n}, 36'd0);
        both_word("R3 read beside blocked write");
        settle();
        chk("R3 full_n after one read", {35'd0, full_n}, 36'd1);
        chk("R5 afull_n with one free", {35'd0, afull_n}, 36'd0);
        for (int k = 0; k < 63; k++) rd_word();
        settle();
        chk("R2 empty_n after drain", {35'd0, empty_n}, 36'd0);

        // Write and read on the same edge at the empty limit
        both_word("R2 read blocked beside write");
        settle();
        chk("R2 empty_n after write", {35'd0, empty_n}, 36'd1);
        rd_word();

        // R6: every preset, select changed after reset release
        for (int c = 0; c < 4; c++) begin
            do_reset(2'(c), 1'b0);
            for (int k = 0; k < 16 - 4 * c; k++) wr_word();
            settle();
            chk($sformatf("R6 aempty_n at threshold code %0d", c), {35'd0, aempty_n}, 36'd0);
            wr_word();
            settle();
            chk($sformatf("R6 aempty_n above threshold code %0d", c), {35'd0, aempty_n}, 36'd1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end
endmodule